// File: doc/BRIEF.md
# Period Timer with Compare-Match Clear

A byte-addressed up-counter for a small controller's peripheral bus. It counts one of three tick sources. The first is the internal instruction tick, which is the system clock divided by `INT_DIV`. The second is rising edges of an external clock pin that pass through a flip-flop synchronizer. The third is rising edges of that pin taken straight from a single sample, without the synchronizer chain.

Software writes the counter one byte at a time and reads it back the same way. Software also writes a small control register and reads and clears an overflow flag.

A neighbouring compare unit supplies a compare value and a mode code. In the special-event mode, the counter returns to zero on the tick after it reaches the compare value, so the compare value sets the period. This clear never raises the overflow flag. A bus write to a counter byte overrides the clear. In the unsynchronized mode the counter keeps counting while the core sleeps, and an overflow in that mode raises a wake request.

Top module: `evt_timer`

## Requirements
- R1: After reset the control register, both counter bytes and the overflow flag all read zero, and `osc_en_o` and `wake_o` are low.
- R2: Register selects are 0 for control, 1 for the counter low byte, 2 for the counter high byte and 3 for the flag. Control bit 0 enables counting and bit 1 selects the external pin. With bit 1 clear, the enabled counter advances by one on every internal tick.
- R3: A write to one counter byte replaces only that byte, and the other byte is unchanged. The counter does not advance in a cycle that carries a counter-byte write.
- R4: Only a natural rollover from all ones to zero sets the flag (select 3, bit 0). The flag stays set until software writes 0 to it.
- R5: With control bits 1 set and 2 clear, the counter advances once per rising edge of the pin. The increment becomes visible after the third clock edge at which the pin reads high.
- R6: With control bits 1 and 2 both set, the counter advances at the first clock edge at which the pin reads high after being low.
- R7: While `sleep_i` is high, the internal and synchronized modes hold the count, and the unsynchronized mode keeps counting.
- R8: `wake_o` is high exactly when the flag is set and `sleep_i` is high.
- R9: With `cmp_mode_i` equal to 4'b1011 in a synchronized mode, a tick that finds the count equal to `cmp_val_i` loads zero instead of count+1, giving a period of compare+1 ticks. This clear never sets the flag, even when the compare value is all ones.
- R10: A counter-byte write in the same cycle as a compare clear keeps the written value, and the clear is dropped.
- R11: In the unsynchronized mode a compare match does not clear the counter.
- R12: `osc_en_o` follows control bit 3.
- R13: Any `cmp_mode_i` value other than 4'b1011 leaves the counter free-running through the compare value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_i | input | 1 | Core sleep indication |
| ext_clk_i | input | 1 | External count pin |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write register select |
| wr_data_i | input | CNT_W/2 | Write data |
| rd_sel_i | input | 2 | Read register select |
| rd_data_o | output | CNT_W/2 | Read data for the selected register |
| cmp_val_i | input | CNT_W | Compare value from the compare unit |
| cmp_mode_i | input | 4 | Compare mode code |
| osc_en_o | output | 1 | Oscillator enable, control bit 3 |
| wake_o | output | 1 | Wake request |

## Verification
The bench builds the block with `CNT_W` of 16, `SYNC_STAGES` of 2 and `INT_DIV` of 1. With an internal tick on every clock, the number of ticks in an enable window equals the number of clock edges, so period, carry, rollover and write-versus-clear results can be predicted exactly per cycle. The two-stage synchronizer sets a known three-edge latency on the pin, and the bench checks it against the one-edge latency of the direct path. The 16-bit width places the all-ones rollover and an all-ones compare value within a few ticks of a preloaded count.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_LO   = 2'd1,
        SEL_HI   = 2'd2,
        SEL_FLAG = 2'd3
    } reg_sel_e;

    localparam int CTRL_W      = 4;
    localparam int CTRL_EN     = 0;
    localparam int CTRL_EXT    = 1;
    localparam int CTRL_NOSYNC = 2;
    localparam int CTRL_OSC    = 3;

    localparam logic [3:0] CMP_SPECIAL = 4'b1011;
endpackage

// File: rtl/tmr_tick_src.sv
module tmr_tick_src #(
    parameter int INT_DIV     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_i,
    input  logic ext_sel_i,
    input  logic raw_sel_i,
    output logic tick_o
);
    localparam int DIV_W = (INT_DIV > 1) ? $clog2(INT_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(INT_DIV - 1);

    typedef struct packed {
        logic [SYNC_STAGES:0] chain;
        logic                 raw;
        logic [DIV_W-1:0]     div;
    } src_st_t;

    src_st_t cur_q, nxt_d;
    logic    sync_tick, raw_tick, int_tick;

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.chain = {cur_q.chain[SYNC_STAGES-1:0], ext_i};
        nxt_d.raw   = ext_i;
        nxt_d.div   = (cur_q.div == DIV_LAST) ? '0 : cur_q.div + 1'b1;
        sync_tick   = cur_q.chain[SYNC_STAGES-1] & ~cur_q.chain[SYNC_STAGES];
        raw_tick    = ext_i & ~cur_q.raw;
        int_tick    = (cur_q.div == DIV_LAST);
        tick_o      = ext_sel_i ? (raw_sel_i ? raw_tick : sync_tick) : int_tick;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    AST_SYNC_SINGLE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        sync_tick |=> !sync_tick); // R5
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             en_i,
    input  logic             sleep_i,
    input  logic             async_i,
    input  logic             cmp_en_i,
    input  logic [CNT_W-1:0] cmp_val_i,
    input  logic             wr_lo_i,
    input  logic             wr_hi_i,
    input  logic             wr_flag_i,
    input  logic [CNT_W/2-1:0] wr_data_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             flag_o
);
    localparam int HALF = CNT_W / 2;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             flag;
    } core_st_t;

    core_st_t cur_q, nxt_d;
    logic     step, clr, wr_cnt;

    always_comb begin
        nxt_d  = cur_q;
        wr_cnt = wr_lo_i | wr_hi_i;
        step   = tick_i & en_i & (~sleep_i | async_i);
        clr    = step & cmp_en_i & ~async_i & (cur_q.cnt == cmp_val_i);
        if (wr_lo_i) begin
            nxt_d.cnt[HALF-1:0] = wr_data_i;
        end else if (wr_hi_i) begin
            nxt_d.cnt[CNT_W-1:HALF] = wr_data_i;
        end else if (step) begin
            if (clr) begin
                nxt_d.cnt = '0;
            end else begin
                nxt_d.cnt = cur_q.cnt + 1'b1;
                if (&cur_q.cnt) nxt_d.flag = 1'b1;
            end
        end
        if (wr_flag_i) nxt_d.flag = wr_data_i[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign cnt_o  = cur_q.cnt;
    assign flag_o = cur_q.flag;

    AST_CLEAR_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !wr_cnt && !wr_flag_i && !cur_q.flag) |=> !cur_q.flag); // R9
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo_i |=> (cur_q.cnt[HALF-1:0] == $past(wr_data_i))
                    && (cur_q.cnt[CNT_W-1:HALF] == $past(cur_q.cnt[CNT_W-1:HALF]))); // R10
    AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_i && !async_i && !wr_cnt) |=> $stable(cur_q.cnt)); // R7
    AST_ASYNC_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (async_i && step && !wr_cnt && (cur_q.cnt == cmp_val_i))
            |=> (cur_q.cnt == $past(cur_q.cnt) + 1'b1)); // R11
    AST_ROLLOVER_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr && !wr_cnt && !wr_flag_i && (&cur_q.cnt)) |=> cur_q.flag); // R4
endmodule

// File: rtl/evt_timer.sv
module evt_timer #(
    parameter int CNT_W       = 16,
    parameter int INT_DIV     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sleep_i,
    input  logic               ext_clk_i,
    input  logic               wr_en_i,
    input  logic [1:0]         wr_sel_i,
    input  logic [CNT_W/2-1:0] wr_data_i,
    input  logic [1:0]         rd_sel_i,
    output logic [CNT_W/2-1:0] rd_data_o,
    input  logic [CNT_W-1:0]   cmp_val_i,
    input  logic [3:0]         cmp_mode_i,
    output logic               osc_en_o,
    output logic               wake_o
);
    import tmr_pkg::*;

    localparam int HALF = CNT_W / 2;

    logic [CTRL_W-1:0] ctrl_q, ctrl_d;
    logic [CNT_W-1:0]  cnt;
    logic              flag, tick, async_mode;
    logic              wr_lo, wr_hi, wr_flag;
    reg_sel_e          wsel, rsel;

    always_comb begin
        wsel       = reg_sel_e'(wr_sel_i);
        rsel       = reg_sel_e'(rd_sel_i);
        ctrl_d     = ctrl_q;
        if (wr_en_i && wsel == SEL_CTRL) ctrl_d = wr_data_i[CTRL_W-1:0];
        wr_lo      = wr_en_i && (wsel == SEL_LO);
        wr_hi      = wr_en_i && (wsel == SEL_HI);
        wr_flag    = wr_en_i && (wsel == SEL_FLAG);
        async_mode = ctrl_q[CTRL_EXT] & ctrl_q[CTRL_NOSYNC];
        case (rsel)
            SEL_CTRL: rd_data_o = {{(HALF-CTRL_W){1'b0}}, ctrl_q};
            SEL_LO:   rd_data_o = cnt[HALF-1:0];
            SEL_HI:   rd_data_o = cnt[CNT_W-1:HALF];
            default:  rd_data_o = {{(HALF-1){1'b0}}, flag};
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    tmr_tick_src #(.INT_DIV(INT_DIV), .SYNC_STAGES(SYNC_STAGES)) u_src (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_i     (ext_clk_i),
        .ext_sel_i (ctrl_q[CTRL_EXT]),
        .raw_sel_i (ctrl_q[CTRL_NOSYNC]),
        .tick_o    (tick)
    );

    tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .en_i      (ctrl_q[CTRL_EN]),
        .sleep_i   (sleep_i),
        .async_i   (async_mode),
        .cmp_en_i  (cmp_mode_i == CMP_SPECIAL),
        .cmp_val_i (cmp_val_i),
        .wr_lo_i   (wr_lo),
        .wr_hi_i   (wr_hi),
        .wr_flag_i (wr_flag),
        .wr_data_i (wr_data_i),
        .cnt_o     (cnt),
        .flag_o    (flag)
    );

    assign osc_en_o = ctrl_q[CTRL_OSC];
    assign wake_o   = flag & sleep_i;

    AST_WAKE_NEEDS_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> sleep_i); // R8
endmodule

// File: tb/tb_evt_timer.sv
module tb_evt_timer;
    localparam int CNT_W = 16;
    localparam int HALF  = CNT_W / 2;
    localparam int NVEC  = 10;

    logic             clk = 1'b0, rst_n = 1'b0, sleep = 1'b0, ext = 1'b0;
    logic             wr_en = 1'b0;
    logic [1:0]       wr_sel = 2'd0, rd_sel = 2'd0;
    logic [HALF-1:0]  wr_data = '0, rd_data;
    logic [CNT_W-1:0] cmp_val = '0;
    logic [3:0]       cmp_mode = 4'd0;
    logic             osc_en, wake;
    int               n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    evt_timer #(.CNT_W(CNT_W), .INT_DIV(1), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .sleep_i(sleep), .ext_clk_i(ext),
        .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
        .rd_sel_i(rd_sel), .rd_data_o(rd_data), .cmp_val_i(cmp_val),
        .cmp_mode_i(cmp_mode), .osc_en_o(osc_en), .wake_o(wake)
    );

    // {start, ticks, mode, compare, expected count, 3'b0, expected flag}
    localparam logic [63:0] VEC [NVEC] = '{
        {16'h0000, 8'd5,  4'h0, 16'h0000, 16'h0005, 3'b0, 1'b0},  // R2
        {16'h00FE, 8'd3,  4'h0, 16'h0000, 16'h0101, 3'b0, 1'b0},  // R2 carry
        {16'hFFFE, 8'd3,  4'h0, 16'h0000, 16'h0001, 3'b0, 1'b1},  // R4
        {16'h0000, 8'd10, 4'hB, 16'h0004, 16'h0000, 3'b0, 1'b0},  // R9
        {16'h0002, 8'd4,  4'hB, 16'h0003, 16'h0002, 3'b0, 1'b0},  // R9
        {16'hFFFD, 8'd4,  4'hB, 16'hFFFF, 16'h0001, 3'b0, 1'b0},  // R9 no flag
        {16'hFFFE, 8'd3,  4'h5, 16'h0000, 16'h0001, 3'b0, 1'b1},  // R13
        {16'h0000, 8'd4,  4'hB, 16'h0000, 16'h0000, 3'b0, 1'b0},  // R9
        {16'h1234, 8'd2,  4'h3, 16'h1235, 16'h1236, 3'b0, 1'b0},  // R13
        {16'h0010, 8'd3,  4'hB, 16'h0005, 16'h0013, 3'b0, 1'b0}   // R9 past compare
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [HALF-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [HALF-1:0] d);
        @(negedge clk);
        rd_sel = sel;
        #1 d = rd_data;
    endtask

    task automatic rd_cnt(output logic [CNT_W-1:0] c);
        logic [HALF-1:0] lo, hi;
        rd(2'd1, lo);
        rd(2'd2, hi);
        c = {hi, lo};
    endtask

    task automatic load(input logic [CNT_W-1:0] v);
        wr(2'd0, 8'h00);
        wr(2'd1, v[HALF-1:0]);
        wr(2'd2, v[CNT_W-1:HALF]);
        wr(2'd3, 8'h00);
    endtask

    task automatic pulse(input int hi, input int lo);
        @(negedge clk) ext = 1'b1;
        repeat (hi) @(negedge clk);
        ext = 1'b0;
        repeat (lo) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [HALF-1:0]  b;
        logic [CNT_W-1:0] c;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, b); chk("R1 ctrl", b, 0);
        rd_cnt(c);   chk("R1 count", c, 0);
        rd(2'd3, b); chk("R1 flag", b, 0);
        chk("R1 osc_en", osc_en, 0);
        chk("R1 wake", wake, 0);

        // vector table: internal ticks, one per clock
        for (int i = 0; i < NVEC; i++) begin
            cmp_mode = VEC[i][39:36];
            cmp_val  = VEC[i][35:20];
            load(VEC[i][63:48]);
            wr(2'd0, 8'h01);
            repeat (int'(VEC[i][47:40]) - 1) @(posedge clk);
            wr(2'd0, 8'h00);
            rd_cnt(c);   chk($sformatf("R2/R9/R13 vec%0d count", i), c, VEC[i][19:4]);
            rd(2'd3, b); chk($sformatf("R4/R9 vec%0d flag", i), b, {7'd0, VEC[i][0]});
        end

        // R4 flag holds, then clears by write
        cmp_mode = 4'h0;
        load(16'hFFFF);
        wr(2'd0, 8'h01); wr(2'd0, 8'h00);
        repeat (5) @(posedge clk);
        rd(2'd3, b); chk("R4 flag held", b, 1);
        wr(2'd3, 8'h00);
        rd(2'd3, b); chk("R4 flag cleared", b, 0);

        // R3 byte write touches one byte only
        load(16'hABCD);
        wr(2'd1, 8'h12);
        rd_cnt(c); chk("R3 byte write", c, 16'hAB12);

        // R10 write beats compare clear, no advance in write cycle
        cmp_mode = 4'hB; cmp_val = 16'h0007;
        load(16'h0007);
        wr(2'd0, 8'h01);
        wr(2'd1, 8'h40);
        wr(2'd0, 8'h00);
        rd_cnt(c); chk("R10 write wins", c, 16'h0041);

        // R12 oscillator enable
        wr(2'd0, 8'h08); chk("R12 osc on", osc_en, 1);
        wr(2'd0, 8'h00); chk("R12 osc off", osc_en, 0);

        // R7 internal mode holds in sleep
        cmp_mode = 4'h0;
        load(16'h0000);
        sleep = 1'b1;
        wr(2'd0, 8'h01);
        repeat (5) @(posedge clk);
        wr(2'd0, 8'h00);
        sleep = 1'b0;
        rd_cnt(c); chk("R7 internal sleep", c, 0);

        // R5 synchronized external mode and its latency
        wr(2'd0, 8'h03);
        repeat (4) @(posedge clk);
        @(negedge clk) ext = 1'b1;
        @(posedge clk); rd(2'd1, b); chk("R5 edge1", b, 0);
        @(posedge clk); rd(2'd1, b); chk("R5 edge2", b, 0);
        @(posedge clk); rd(2'd1, b); chk("R5 edge3", b, 1);
        @(negedge clk) ext = 1'b0;
        repeat (3) @(negedge clk);
        pulse(3, 3); pulse(3, 3);
        repeat (4) @(posedge clk);
        rd(2'd1, b); chk("R5 three edges", b, 3);
        sleep = 1'b1;
        pulse(3, 3); pulse(3, 3);
        repeat (4) @(posedge clk);
        rd(2'd1, b); chk("R7 sync sleep", b, 3);
        sleep = 1'b0;

        // R6 unsynchronized mode, one-edge latency; R7 runs in sleep
        wr(2'd0, 8'h07);
        repeat (2) @(posedge clk);
        @(negedge clk) ext = 1'b1;
        @(posedge clk); rd(2'd1, b); chk("R6 first edge", b, 4);
        @(negedge clk) ext = 1'b0;
        sleep = 1'b1;
        pulse(2, 2); pulse(2, 2);
        rd(2'd1, b); chk("R7 async sleep", b, 6);
        sleep = 1'b0;

        // R11 no clear in unsynchronized mode; sync mode clears
        cmp_mode = 4'hB; cmp_val = 16'h0003;
        load(16'h0002);
        wr(2'd0, 8'h07);
        pulse(2, 2); pulse(2, 2);
        rd_cnt(c); chk("R11 async no clear", c, 16'h0004);
        load(16'h0002);
        wr(2'd0, 8'h03);
        repeat (3) @(posedge clk);
        pulse(3, 3); pulse(3, 3);
        repeat (4) @(posedge clk);
        rd_cnt(c); chk("R9 sync clear", c, 16'h0000);

        // R8 wake on overflow during sleep
        cmp_mode = 4'h0;
        load(16'hFFFF);
        wr(2'd0, 8'h07);
        sleep = 1'b1;
        pulse(2, 2);
        rd(2'd3, b); chk("R4 async overflow flag", b, 1);
        chk("R8 wake high", wake, 1);
        @(negedge clk) sleep = 1'b0;
        #1 chk("R8 wake low", wake, 0);
        wr(2'd0, 8'h00);
        wr(2'd3, 8'h00);
        rd(2'd3, b); chk("R4 clear", b, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule